// File: doc/BRIEF.md
# Configurable Two-Level AND-OR Array

This block is a sum-of-products array that can be reconfigured at run time. It has six inputs, six product terms and four outputs. A serially loaded configuration word sets three things: which true or complemented input literals each product term takes (the AND plane), which terms each output ORs together (the OR plane), and a 64-entry truth table for each output. A two-bit mode input picks the structure the array uses:
- a fully programmable AND and OR plane;
- a fixed OR plane, in which each output has its own small group of terms;
- an all-minterms mode, in which the array acts as a lookup memory holding each output's truth table.

The configuration is shifted in one bit per clock while the load enable is high. The combinational outputs are forced to zero during that time. A registered copy of the outputs is provided for sequential use.

Top module: `pla_array`

## Requirements
- R1: Configuration bit 2*(t*6+i) connects the true literal of input x[i] to term t, and bit 2*(t*6+i)+1 connects the complemented literal.
- R2: When neither literal bit of an input is set, that input does not affect the term. A term with no literals connected evaluates to 1.
- R3: When both literal bits of an input are set for a term, that term is 0 for every input value.
- R4: In mode 2'b00 (full), output o is the OR of every term t whose bit 72+o*6+t is set. An output with no terms connected is 0.
- R5: In mode 2'b01 (fixed OR), term t feeds only output t mod 4, and the OR-plane bits have no effect.
- R6: In mode 2'b10 (all minterms), output o equals configuration bit 96+o*64+x, where x is read as binary with x[0] as the LSB. The AND-plane and OR-plane bits have no effect.
- R7: Mode 2'b11 behaves exactly like full mode.
- R8: While cfg_load is high, each rising edge shifts cfg_sdi into bit 0 and moves every other bit up one place, so a 352-bit word goes in MSB first. While cfg_load is low, the configuration does not change.
- R9: While cfg_load is high, dout is 0.
- R10: On each rising edge, dout_q takes the value dout had before the edge. A synchronous reset clears both dout_q and the whole configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Array structure select |
| x | input | 6 | Logic inputs |
| cfg_load | input | 1 | Enables shifting of the configuration chain |
| cfg_sdi | input | 1 | Serial configuration data |
| dout | output | 4 | Combinational outputs |
| dout_q | output | 4 | Registered outputs |

## Verification
The hardest case to reach from the ports is a single configuration that shows, across all modes, that the bits a mode does not use are really ignored. To do this, the bench loads one 352-bit word that fills the AND plane, the OR plane and the truth table with contradictory content. This includes a term with both literals of one input set and a term that no OR-plane bit selects. The bench then sweeps all 64 input values in each mode without reloading. Each mode's expected outputs are written out as a formula of its own, so a bit landing in the wrong field or being read by the wrong mode shows up as a mismatch.

// File: rtl/pla_pkg.sv
package pla_pkg;

    typedef enum logic [1:0] {
        MODE_FULL  = 2'b00,
        MODE_FIXOR = 2'b01,
        MODE_MINT  = 2'b10,
        MODE_ALT   = 2'b11
    } pla_mode_e;

endpackage

// File: rtl/pla_cfg_chain.sv
module pla_cfg_chain #(
    parameter int W = 352
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         sdi,
    output logic [W-1:0] cfg
);

    typedef struct packed {
        logic [W-1:0] bits;
    } chain_t;

    chain_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.bits = {st_q.bits[W-2:0], sdi};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cfg = st_q.bits;

    // R8
    shift_in_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (cfg[0] == $past(sdi)) && (cfg[W-1:1] == $past(cfg[W-2:0])));

    // R8
    hold_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !$past(rst)) |=> $stable(cfg));

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
    parameter int N_IN   = 6,
    parameter int N_TERM = 6,
    localparam int AND_W = 2 * N_IN * N_TERM
) (
    input  logic [N_IN-1:0]   x,
    input  logic [AND_W-1:0]  lit_cfg,
    output logic [N_TERM-1:0] term
);

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        logic prod;
        always_comb begin
            prod = 1'b1;
            for (int i = 0; i < N_IN; i++) begin
                if (lit_cfg[2*(t*N_IN+i)]   && !x[i]) prod = 1'b0;
                if (lit_cfg[2*(t*N_IN+i)+1] &&  x[i]) prod = 1'b0;
            end
        end
        assign term[t] = prod;
    end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane
    import pla_pkg::*;
#(
    parameter int N_IN   = 6,
    parameter int N_TERM = 6,
    parameter int N_OUT  = 4,
    localparam int DEPTH = 1 << N_IN,
    localparam int OR_W  = N_OUT * N_TERM,
    localparam int ROM_W = N_OUT * DEPTH
) (
    input  pla_mode_e         mode,
    input  logic [N_IN-1:0]   x,
    input  logic [N_TERM-1:0] term,
    input  logic [OR_W-1:0]   sel_cfg,
    input  logic [ROM_W-1:0]  tbl_cfg,
    output logic [N_OUT-1:0]  y
);

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        logic [DEPTH-1:0] tbl_row;
        logic             sum;
        assign tbl_row = tbl_cfg[o*DEPTH +: DEPTH];
        always_comb begin
            sum = 1'b0;
            case (mode)
                MODE_FIXOR: begin
                    for (int t = 0; t < N_TERM; t++) begin
                        if ((t % N_OUT) == o) sum = sum | term[t];
                    end
                end
                MODE_MINT: sum = tbl_row[x];
                default: begin
                    for (int t = 0; t < N_TERM; t++) begin
                        sum = sum | (term[t] & sel_cfg[o*N_TERM+t]);
                    end
                end
            endcase
        end
        assign y[o] = sum;
    end

endmodule

// File: rtl/pla_array.sv
module pla_array
    import pla_pkg::*;
#(
    parameter int N_IN   = 6,
    parameter int N_TERM = 6,
    parameter int N_OUT  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode,
    input  logic [N_IN-1:0]  x,
    input  logic             cfg_load,
    input  logic             cfg_sdi,
    output logic [N_OUT-1:0] dout,
    output logic [N_OUT-1:0] dout_q
);

    localparam int DEPTH   = 1 << N_IN;
    localparam int AND_W   = 2 * N_IN * N_TERM;
    localparam int OR_W    = N_OUT * N_TERM;
    localparam int ROM_W   = N_OUT * DEPTH;
    localparam int OR_OFF  = AND_W;
    localparam int ROM_OFF = AND_W + OR_W;
    localparam int CFG_W   = AND_W + OR_W + ROM_W;

    typedef struct packed {
        logic [N_OUT-1:0] outs;
    } oreg_t;

    logic [CFG_W-1:0]  cfg;
    logic [N_TERM-1:0] term;
    logic [N_OUT-1:0]  y;
    oreg_t             st_d, st_q;

    pla_cfg_chain #(.W(CFG_W)) u_chain (
        .clk  (clk),
        .rst  (rst),
        .load (cfg_load),
        .sdi  (cfg_sdi),
        .cfg  (cfg)
    );

    pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
        .x       (x),
        .lit_cfg (cfg[AND_W-1:0]),
        .term    (term)
    );

    pla_or_plane #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
        .mode    (pla_mode_e'(mode)),
        .x       (x),
        .term    (term),
        .sel_cfg (cfg[OR_OFF +: OR_W]),
        .tbl_cfg (cfg[ROM_OFF +: ROM_W]),
        .y       (y)
    );

    assign dout = cfg_load ? '0 : y;

    always_comb begin
        st_d      = st_q;
        st_d.outs = dout;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign dout_q = st_q.outs;

    // R9
    load_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_load |-> (dout == '0));

    // R10
    reg_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (dout_q == $past(dout)));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (dout_q == '0));

endmodule

// File: tb/tb_pla_array.sv
module tb_pla_array;

    localparam int W       = 352;
    localparam int OR_OFF  = 72;
    localparam int ROM_OFF = 96;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] mode;
    logic [5:0] x;
    logic       cfg_load;
    logic       cfg_sdi;
    logic [3:0] dout;
    logic [3:0] dout_q;

    logic [W-1:0] cfgv;
    int total = 0;
    int bad   = 0;

    pla_array dut (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .x        (x),
        .cfg_load (cfg_load),
        .cfg_sdi  (cfg_sdi),
        .dout     (dout),
        .dout_q   (dout_q)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // R1: literal bit positions
    task automatic lit(input int t, input int i, input int comp);
        cfgv[2*(t*6+i)+comp] = 1'b1;
    endtask

    function automatic logic [3:0] exp_full(input logic [5:0] v);
        return {1'b0, 1'b0, 1'b1, (v[0] & ~v[1]) | v[2]};
    endfunction

    function automatic logic [3:0] exp_fix(input logic [5:0] v);
        return {1'b0, 1'b1, v[2] | ~v[4], (v[0] & ~v[1]) | v[5]};
    endfunction

    function automatic logic [3:0] exp_mint(input logic [5:0] v);
        return {(v < 6'd3), v[5], (v == 6'd37), v[0] ^ v[1]};
    endfunction

    function automatic logic [3:0] exp_of(input int kind, input logic [5:0] v);
        if (kind == 1) return exp_fix(v);
        if (kind == 2) return exp_mint(v);
        return exp_full(v);
    endfunction

    task automatic build_cfg();
        cfgv = '0;
        lit(0, 0, 0); lit(0, 1, 1);
        lit(1, 2, 0);
        lit(3, 3, 0); lit(3, 3, 1);
        lit(4, 5, 0);
        lit(5, 4, 1);
        cfgv[OR_OFF + 0*6 + 0] = 1'b1;
        cfgv[OR_OFF + 0*6 + 1] = 1'b1;
        cfgv[OR_OFF + 1*6 + 2] = 1'b1;
        cfgv[OR_OFF + 2*6 + 3] = 1'b1;
        for (int a = 0; a < 64; a++) begin
            logic [3:0] e;
            e = exp_mint(6'(a));
            for (int o = 0; o < 4; o++) cfgv[ROM_OFF + o*64 + a] = e[o];
        end
    endtask

    // R8 R9: shift the word in MSB first, check outputs stay quiet
    task automatic load_cfg();
        for (int k = W-1; k >= 0; k--) begin
            @(negedge clk);
            cfg_load = 1'b1;
            cfg_sdi  = cfgv[k];
            if (k == W/2) begin
                #1;
                chk("R9 dout during load", dout, 4'b0000);
            end
        end
        @(negedge clk);
        cfg_load = 1'b0;
        cfg_sdi  = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        #1;
        chk("R10 dout_q after reset", dout_q, 4'b0000);
        chk("R4 dout with empty config", dout, 4'b0000);
    endtask

    // sweeps all input values; R10 checked against the previous value
    task automatic sweep(input string req, input logic [1:0] m, input int kind);
        logic [3:0] prev;
        for (int v = 0; v < 64; v++) begin
            @(negedge clk);
            if (v > 0) chk("R10 registered copy", dout_q, prev);
            mode = m;
            x    = 6'(v);
            #1;
            prev = exp_of(kind, 6'(v));
            chk(req, dout, prev);
        end
    endtask

    task automatic t_full();
        sweep("R1 R2 R3 R4 full mode", 2'b00, 0);
    endtask

    task automatic t_fixed();
        sweep("R5 fixed OR mode", 2'b01, 1);
    endtask

    task automatic t_mint();
        sweep("R6 all minterms mode", 2'b10, 2);
    endtask

    task automatic t_alt();
        sweep("R7 mode 11 as full", 2'b11, 0);
    endtask

    task automatic t_hold();
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            cfg_sdi = k[0];
        end
        cfg_sdi = 1'b0;
        @(negedge clk);
        mode = 2'b10;
        x    = 6'd37;
        #1;
        chk("R8 config held when load low", dout, exp_mint(6'd37));
        @(negedge clk);
        mode = 2'b00;
        x    = 6'd5;
        #1;
        chk("R8 config held when load low", dout, exp_full(6'd5));
    endtask

    task automatic t_reset_cfg();
        @(negedge clk);
        mode = 2'b10;
        x    = 6'd1;
        #1;
        chk("R6 before reset", dout, exp_mint(6'd1));
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R10 config cleared by reset", dout, 4'b0000);
        chk("R10 dout_q cleared by reset", dout_q, 4'b0000);
    endtask

    initial begin
        #200000;
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst      = 1'b1;
        mode     = 2'b00;
        x        = '0;
        cfg_load = 1'b0;
        cfg_sdi  = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        build_cfg();
        load_cfg();
        t_full();
        t_fixed();
        t_mint();
        t_alt();
        t_hold();
        t_reset_cfg();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule